// File: doc/BRIEF.md
# Serial Data Acquisition Sequencer

This block runs one acquisition burst each time a run flag is seen while it is idle. A burst pairs an audio-style serial ADC with a serial SRAM that accepts streaming writes. The block first selects the SRAM and clocks out a 32-bit write header. It then generates repeated ADC frames, each with a one-bit-period frame strobe and a continuous bit clock. The ADC's serial output is passed straight onto the SRAM data line, and a gated SRAM clock writes every sample bit as it arrives.

While frames run, a laser drive level is high for the first half of each laser cycle and low for the second half. The burst length is set by a fixed nest of counts: frames per laser cycle, laser cycles per acquisition, and a 7-bit acquisition count sampled at the start of the burst. When the last frame ends, the SRAM is released and a one-cycle interrupt pulse is given. A single sequence counter sets all of the timing. Its least significant bit is the ADC bit clock, so one bit period is two master clock cycles and one frame is 2*FRAME_BITS cycles. The header takes exactly one frame slot.

Parameters: FRAME_BITS (bit periods per frame, at least 34), FRAMES_PER_LASER (even), LASER_CYCLES, CNT_W, START_ADDR.

Top module: `acq_burst_seq`

## Requirements
- R1: After reset, with run low, the block stays idle: sram_cs_n=1, and sram_sck, sram_si, adc_lrck, laser_on and irq are all 0.
- R2: adc_bck is 0 during reset and stays 0 through the first two rising clock edges after rst_n rises. It is 1 after the third edge and from then on toggles on every clock edge.
- R3: In idle with run high, the burst starts at the next frame boundary: sram_cs_n falls on the same edge where adc_bck falls. It stays 0 for the whole burst.
- R4: The header uses 32 SRAM clock pulses, one in each of the first 32 bit periods of the burst, sent MSB first. The bits are the opcode 8'b00000010, then 7 zero bits, then the 17-bit START_ADDR. sram_si changes only when adc_bck falls.
- R5: After the header slot, each frame begins with adc_lrck high for exactly one bit period. adc_lrck rises on a falling edge of adc_bck. Frames are FRAME_BITS bit periods long and follow each other with no gap.
- R6: In bit periods 1 to 32 of each frame, sram_si equals adc_sd and sram_sck equals adc_bck. This gives 32 pulses per frame, with the left-channel MSB in period 1.
- R7: Outside the header and data bit periods, sram_sck and sram_si are 0.
- R8: laser_on is 1 during the first FRAMES_PER_LASER/2 frames of each laser cycle and 0 during the rest. It is 0 in the header slot and outside a burst.
- R9: A burst has FRAMES_PER_LASER*LASER_CYCLES*max(cyc_cnt,1) frames. cyc_cnt is sampled at the start of the burst, and later changes to it have no effect.
- R10: On the edge that ends the last frame, irq goes to 1 for exactly one clock cycle, and sram_cs_n returns to 1 on that same edge.
- R11: If run drops during a burst, the burst still completes. If run is still high after the end, the next burst starts exactly 2*FRAME_BITS cycles after irq rose.
- R12: If rst_n is asserted during a burst, sram_cs_n goes to 1 at once, and sram_sck, laser_on and irq go to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Run flag; starts a burst when seen in idle |
| cyc_cnt | input | CNT_W | Acquisitions per burst (0 acts as 1) |
| adc_sd | input | 1 | Serial data from the ADC |
| adc_bck | output | 1 | ADC bit clock |
| adc_lrck | output | 1 | ADC frame strobe |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_sck | output | 1 | Gated SRAM serial clock |
| sram_si | output | 1 | SRAM serial data in |
| laser_on | output | 1 | Laser drive level |
| irq | output | 1 | End-of-burst interrupt pulse |

## Verification
The laser level change and the rise of the frame strobe fall on the same clock edge at the start of each frame. The bench drives bursts with a small frame count per laser cycle, so this happens many times in every burst. At each boundary, both outputs are compared against a model that is built only from the frame index and the bit position. The end of the last frame is a second coincidence: the interrupt pulse, the chip-select release and the end of the strobe pattern all fall on one edge. This is judged by sampling the cycle before, the cycle of, and the cycle after that edge.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HEAD  = 2'd1,
    ST_FRAME = 2'd2,
    ST_DONE  = 2'd3
  } acq_state_e;

  localparam int HDR_BITS  = 32;
  localparam int DATA_BITS = 32;
  localparam logic [7:0] WR_OPCODE = 8'h02;

  // opcode byte followed by a 24-bit right-justified address
  function automatic logic [31:0] make_header(input logic [23:0] addr);
    return {WR_OPCODE, addr};
  endfunction
endpackage

// File: rtl/acq_rst_sync.sv
module acq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q = sync_q[STAGES-1];
endmodule

// File: rtl/acq_seq_timer.sv
module acq_seq_timer #(
  parameter int  FRAME_BITS = 64,
  localparam int SEQ_LEN    = 2 * FRAME_BITS,
  localparam int SW         = $clog2(SEQ_LEN),
  localparam int KW         = SW - 1
) (
  input  logic          clk,
  input  logic          rst_q,
  output logic          bck,
  output logic [KW-1:0] bit_idx,
  output logic          wrap
);
  logic [SW-1:0] seq_q, seq_d;
  logic          count_en;
  logic          at_end;

  assign count_en = 1'b1;
  assign at_end   = (seq_q == SW'(SEQ_LEN - 1));

  always_comb begin
    seq_d = seq_q;
    if (count_en) seq_d = at_end ? '0 : seq_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) seq_q <= '0;
    else        seq_q <= seq_d;
  end

  assign bck     = seq_q[0];
  assign bit_idx = seq_q[SW-1:1];
  assign wrap    = at_end;

  // R2: bit clock alternates on every edge once out of reset
  assert_bck_rise_R2: assert property (@(posedge clk) disable iff (!rst_q)
    !bck |=> bck);
  assert_bck_fall_R2: assert property (@(posedge clk) disable iff (!rst_q)
    bck |=> !bck);
endmodule

// File: rtl/acq_burst_ctr.sv
module acq_burst_ctr #(
  parameter int FRAMES_PER_LASER = 16,
  parameter int LASER_CYCLES     = 32,
  parameter int CNT_W            = 7
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt_in,
  output logic             laser_hi,
  output logic             last
);
  localparam int FW = (FRAMES_PER_LASER > 1) ? $clog2(FRAMES_PER_LASER) : 1;
  localparam int LW = (LASER_CYCLES > 1) ? $clog2(LASER_CYCLES) : 1;
  localparam logic [FW-1:0] F_LAST = FW'(FRAMES_PER_LASER - 1);
  localparam logic [FW-1:0] F_HALF = FW'(FRAMES_PER_LASER / 2);
  localparam logic [LW-1:0] L_LAST = LW'(LASER_CYCLES - 1);

  logic [FW-1:0]    frame_q, frame_d;
  logic [LW-1:0]    lcyc_q, lcyc_d;
  logic [CNT_W-1:0] acq_q, acq_d;
  logic [CNT_W-1:0] goal_q, goal_d;
  logic             frame_end, lcyc_end, acq_end;

  assign frame_end = (frame_q == F_LAST);
  assign lcyc_end  = (lcyc_q == L_LAST);
  assign acq_end   = ({1'b0, acq_q} + (CNT_W+1)'(1)) >= {1'b0, goal_q};

  always_comb begin
    frame_d = frame_q;
    lcyc_d  = lcyc_q;
    acq_d   = acq_q;
    goal_d  = goal_q;
    if (load) begin
      frame_d = '0;
      lcyc_d  = '0;
      acq_d   = '0;
      goal_d  = cnt_in;
    end else if (step) begin
      frame_d = frame_end ? '0 : frame_q + 1'b1;
      if (frame_end) lcyc_d = lcyc_end ? '0 : lcyc_q + 1'b1;
      if (frame_end && lcyc_end) acq_d = acq_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      frame_q <= '0;
      lcyc_q  <= '0;
      acq_q   <= '0;
      goal_q  <= '0;
    end else begin
      frame_q <= frame_d;
      lcyc_q  <= lcyc_d;
      acq_q   <= acq_d;
      goal_q  <= goal_d;
    end
  end

  assign laser_hi = (frame_q < F_HALF);
  assign last     = frame_end && lcyc_end && acq_end;

  // R9: the burst length latched at start ignores later count changes
  assert_goal_hold_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !load |=> $stable(goal_q));
  // R8: every laser cycle opens with the drive high
  assert_laser_open_R8: assert property (@(posedge clk) disable iff (!rst_q)
    load |=> laser_hi);
endmodule

// File: rtl/acq_burst_seq.sv
module acq_burst_seq
  import acq_pkg::*;
#(
  parameter int          FRAME_BITS       = 64,
  parameter int          FRAMES_PER_LASER = 16,
  parameter int          LASER_CYCLES     = 32,
  parameter int          CNT_W            = 7,
  parameter logic [16:0] START_ADDR       = 17'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cyc_cnt,
  input  logic             adc_sd,
  output logic             adc_bck,
  output logic             adc_lrck,
  output logic             sram_cs_n,
  output logic             sram_sck,
  output logic             sram_si,
  output logic             laser_on,
  output logic             irq
);
  localparam int SW = $clog2(2 * FRAME_BITS);
  localparam int KW = SW - 1;
  localparam logic [KW-1:0] HDR_END   = KW'(HDR_BITS);
  localparam logic [KW-1:0] DATA_LAST = KW'(DATA_BITS);
  localparam logic [31:0]   HEADER    = make_header({7'd0, START_ADDR});

  logic          rst_q;
  logic          bck, wrap;
  logic [KW-1:0] bit_idx;
  logic          start, step, laser_hi, last;
  logic          hdr_win, dat_win;
  acq_state_e    state_q, state_d;

  acq_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  acq_seq_timer #(.FRAME_BITS(FRAME_BITS)) u_seq (
    .clk     (clk),
    .rst_q   (rst_q),
    .bck     (bck),
    .bit_idx (bit_idx),
    .wrap    (wrap)
  );

  assign start = (state_q == ST_IDLE) && run && wrap;
  assign step  = (state_q == ST_FRAME) && wrap;

  acq_burst_ctr #(
    .FRAMES_PER_LASER (FRAMES_PER_LASER),
    .LASER_CYCLES     (LASER_CYCLES),
    .CNT_W            (CNT_W)
  ) u_ctr (
    .clk      (clk),
    .rst_q    (rst_q),
    .load     (start),
    .step     (step),
    .cnt_in   (cyc_cnt),
    .laser_hi (laser_hi),
    .last     (last)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_HEAD;
      ST_HEAD:  if (wrap) state_d = ST_FRAME;
      ST_FRAME: if (wrap && last) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // output decode from sequence position and state
  assign hdr_win = (state_q == ST_HEAD) && (bit_idx < HDR_END);
  assign dat_win = (state_q == ST_FRAME) && (bit_idx != '0) && (bit_idx <= DATA_LAST);

  assign adc_bck   = bck;
  assign adc_lrck  = (state_q == ST_FRAME) && (bit_idx == '0);
  assign sram_cs_n = !((state_q == ST_HEAD) || (state_q == ST_FRAME));
  assign sram_sck  = bck && (hdr_win || dat_win);
  assign sram_si   = hdr_win ? HEADER[~bit_idx[4:0]] : (dat_win && adc_sd);
  assign laser_on  = (state_q == ST_FRAME) && laser_hi;
  assign irq       = (state_q == ST_DONE);

  // R7: serial clock only while the memory is selected
  assert_sck_selected_R7: assert property (@(posedge clk) disable iff (!rst_q)
    sram_sck |-> !sram_cs_n);
  // R5: strobe rises with a falling bit clock
  assert_strobe_edge_R5: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(adc_lrck) |-> $fell(adc_bck));
  // R6: no memory clock while the frame strobe is high
  assert_strobe_gap_R6: assert property (@(posedge clk) disable iff (!rst_q)
    adc_lrck |-> !sram_sck);
  // R10: one-cycle interrupt with memory released
  assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_q)
    irq |=> !irq);
  assert_irq_release_R10: assert property (@(posedge clk) disable iff (!rst_q)
    irq |-> sram_cs_n);
  // R4: header data moves only on a falling bit clock
  assert_hdr_stable_R4: assert property (@(posedge clk) disable iff (!rst_q)
    (state_q == ST_HEAD && $past(state_q) == ST_HEAD && !$fell(adc_bck))
      |-> $stable(sram_si));
  // R3: selection begins on a falling bit clock
  assert_cs_align_R3: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(sram_cs_n) |-> $fell(adc_bck));
endmodule

// File: tb/acq_burst_seq_test.sv
module acq_burst_seq_test;
  localparam int FB  = 36;
  localparam int FPL = 4;
  localparam int LC  = 2;
  localparam int SEQ = 2 * FB;

  logic       clk = 1'b0;
  logic       rst_n, run, adc_sd;
  logic [6:0] cyc_cnt;
  logic       adc_bck, adc_lrck, sram_cs_n, sram_sck, sram_si, laser_on, irq;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #4ns clk = ~clk;

  acq_burst_seq #(
    .FRAME_BITS(FB), .FRAMES_PER_LASER(FPL), .LASER_CYCLES(LC),
    .CNT_W(7), .START_ADDR(17'd0)
  ) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .cyc_cnt(cyc_cnt), .adc_sd(adc_sd),
    .adc_bck(adc_bck), .adc_lrck(adc_lrck), .sram_cs_n(sram_cs_n),
    .sram_sck(sram_sck), .sram_si(sram_si), .laser_on(laser_on), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle_outputs(input string req);
    chk(sram_cs_n == 1'b1, req, "sram_cs_n", sram_cs_n, 1);
    chk(sram_sck == 1'b0, req, "sram_sck", sram_sck, 0);
    chk(sram_si == 1'b0, req, "sram_si", sram_si, 0);
    chk(adc_lrck == 1'b0, req, "adc_lrck", adc_lrck, 0);
    chk(laser_on == 1'b0, req, "laser_on", laser_on, 0);
    chk(irq == 1'b0, req, "irq", irq, 0);
  endtask

  // R1 R2: reset state and bit clock start-up
  task automatic test_reset();
    rst_n = 1'b0; run = 1'b0; cyc_cnt = 7'd1; adc_sd = 1'b0;
    repeat (3) @(negedge clk);
    idle_outputs("R1");
    chk(adc_bck == 1'b0, "R2", "adc_bck in reset", adc_bck, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(adc_bck == 1'b0, "R2", "adc_bck edge1", adc_bck, 0);
    @(negedge clk);
    chk(adc_bck == 1'b0, "R2", "adc_bck edge2", adc_bck, 0);
    @(negedge clk);
    chk(adc_bck == 1'b1, "R2", "adc_bck edge3", adc_bck, 1);
    @(negedge clk);
    chk(adc_bck == 1'b0, "R2", "adc_bck edge4", adc_bck, 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      chk(sram_cs_n == 1'b1 && sram_sck == 1'b0, "R1", "idle select", sram_cs_n, 1);
    end
  endtask

  // R3: wait for selection, which must land on a falling bit clock
  task automatic wait_start();
    bit prev_bck;
    int n;
    prev_bck = adc_bck;
    n = 0;
    while (sram_cs_n == 1'b1 && n < 3 * SEQ) begin
      prev_bck = adc_bck;
      @(negedge clk);
      n++;
    end
    chk(sram_cs_n == 1'b0, "R3", "burst started", sram_cs_n, 0);
    chk(n <= SEQ, "R3", "start latency", n, SEQ);
    chk(prev_bck == 1'b1 && adc_bck == 1'b0, "R3", "start on bck fall", adc_bck, 0);
  endtask

  // R4-R10: follow one burst cycle by cycle from the first selected sample
  task automatic follow_burst(input int goal, input bit drop_run);
    int nfr, t_end, k, p, f;
    bit e_bck, e_sck, e_si, e_lrck, e_laser;
    string rq;
    nfr = FPL * LC * ((goal == 0) ? 1 : goal);
    t_end = SEQ * (1 + nfr);
    for (int t = 0; t < t_end; t++) begin
      e_bck = t[0];
      p = t % SEQ;
      k = p / 2;
      if (t < SEQ) begin
        e_lrck = 1'b0; e_laser = 1'b0;
        if (k < 32) begin
          rq = "R4"; e_sck = e_bck; e_si = (k == 6);
        end else begin
          rq = "R7"; e_sck = 1'b0; e_si = 1'b0;
        end
      end else begin
        f = t / SEQ - 1;
        e_lrck = (k == 0);
        // laser change and strobe rise share this edge when p == 0
        e_laser = (f % FPL) < (FPL / 2);
        if (k >= 1 && k <= 32) begin
          rq = "R6"; e_sck = e_bck; e_si = adc_sd;
        end else begin
          rq = "R7"; e_sck = 1'b0; e_si = 1'b0;
        end
      end
      chk(adc_bck == e_bck, "R2", "adc_bck", adc_bck, e_bck);
      chk(sram_cs_n == 1'b0, "R3", "sram_cs_n held", sram_cs_n, 0);
      chk(sram_sck == e_sck, rq, "sram_sck", sram_sck, e_sck);
      chk(sram_si == e_si, rq, "sram_si", sram_si, e_si);
      chk(adc_lrck == e_lrck, "R5", "adc_lrck", adc_lrck, e_lrck);
      chk(laser_on == e_laser, "R8", "laser_on", laser_on, e_laser);
      chk(irq == 1'b0, "R9", "irq early", irq, 0);
      if (t == 40) cyc_cnt = 7'd3;
      if (t == 90 && drop_run) run = 1'b0;
      adc_sd = 1'($urandom % 2);
      @(negedge clk);
    end
    chk(irq == 1'b1, "R10", "irq at end", irq, 1);
    chk(sram_cs_n == 1'b1, "R10", "cs released", sram_cs_n, 1);
    chk(laser_on == 1'b0 && adc_lrck == 1'b0, "R10", "laser/strobe at end", laser_on, 0);
  endtask

  task automatic test_burst(input int goal);
    cyc_cnt = 7'(goal);
    run = 1'b1;
    wait_start();
    follow_burst(goal, 1'b1);
    @(negedge clk);
    chk(irq == 1'b0, "R10", "irq width", irq, 0);
    for (int i = 0; i < 3 * SEQ; i++) begin
      chk(sram_cs_n == 1'b1, "R11", "no restart with run low", sram_cs_n, 1);
      @(negedge clk);
    end
  endtask

  // R11 then R12: rerun with run held high, reset inside the second burst
  task automatic test_rerun_and_reset();
    int n;
    cyc_cnt = 7'd1;
    run = 1'b1;
    wait_start();
    follow_burst(1, 1'b0);
    n = 0;
    while (sram_cs_n == 1'b1 && n < 3 * SEQ) begin
      @(negedge clk);
      n++;
    end
    chk(n == SEQ, "R11", "rerun gap", n, SEQ);
    repeat (SEQ + 10) @(negedge clk);
    chk(sram_cs_n == 1'b0, "R12", "inside burst", sram_cs_n, 0);
    rst_n = 1'b0;
    #1ns;
    chk(sram_cs_n == 1'b1, "R12", "cs on reset", sram_cs_n, 1);
    chk(sram_sck == 1'b0, "R12", "sck on reset", sram_sck, 0);
    chk(laser_on == 1'b0, "R12", "laser on reset", laser_on, 0);
    chk(irq == 1'b0, "R12", "irq on reset", irq, 0);
    run = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2 * SEQ) @(negedge clk);
    idle_outputs("R12");
  endtask

  initial begin
    test_reset();
    test_burst(1);
    test_burst(0);
    test_burst(2);
    test_rerun_and_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule